// File: doc/BRIEF.md
# Multi-Column First-Crossing Result Capture

This block sits beside a row of current-input integrating converter columns that all share one free-running code counter and one phase sequencer. During the discharge phase the sequencer strobes every column's latched comparator once per counter step. The block watches each column's comparator bit and, for each column, keeps the shared counter value at the first strobe that finds the comparator high. The comparator keeps pulsing after it has first tripped, and the block discards every one of those later pulses for the rest of that conversion.

When the counter reaches its top code on a discharge strobe, the conversion is finished. At that edge every column's stored result and its over-range flag change together, and a single-cycle done pulse follows. A column that never tripped during the discharge phase reports the full-scale code with the over-range flag set. Results from the last finished conversion can be read at all times through a column-select multiplexer, and they stay valid while the next conversion is in progress.

Top module: `xcap_array`

## Requirements
- R1: While reset is held and after it is released, before any conversion has finished, `conv_done` is 0 and every column reads back as 0 (over-range flag 0, code 0).
- R2: A strobe with `phase_dis` high and a column's `cmp` bit high, when that column has not yet captured in the current discharge phase, records the value of `count` for that column.
- R3: After a column has captured, later high comparator samples in the same discharge phase do not change its recorded value.
- R4: A high comparator bit has no effect when `phase_dis` is low, even if `strobe` is high, and has no effect during discharge in a cycle where `strobe` is low.
- R5: A column with no capture during a whole discharge phase reads back code 63 (all ones) with the over-range flag set. Whenever the over-range flag reads 1, the code reads all ones.
- R6: Read-back values change only at the end edge, which is the rising clock edge where `phase_dis`, `strobe` are high and `count` is 63. At that edge all columns' codes and flags update together. Before that edge the previous conversion's results stay readable.
- R7: `conv_done` is high for exactly the one cycle after the end edge and is low at all other times.
- R8: The first cycle of `phase_dis` high after it was low starts a new conversion and clears every column's captured state. A capture in that same cycle counts for the new conversion.
- R9: `rd_data` is {over-range flag, code[5:0]} of the column numbered `rd_sel`, so bit 6 is the flag. The value follows `rd_sel` combinationally.
- R10: A first crossing found on the end strobe itself (count 63) records code 63 with the over-range flag 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_dis | input | 1 | Sequencer: discharge phase active |
| strobe | input | 1 | Sequencer: comparator latch strobe |
| count | input | 6 | Shared code counter value |
| cmp | input | 8 | Comparator output bit, one per column |
| rd_sel | input | 3 | Column chosen for read-back |
| rd_data | output | 7 | {over-range flag, code} of the chosen column |
| conv_done | output | 1 | One-cycle pulse after each finished conversion |

## Verification
The columns are given a spread of crossing points in the same conversion: code 0, middle codes, code 63 on the end strobe, and no crossing at all. This separates a correct first-hit latch from one that keeps the last hit, an off-by-one end detect, and a wrong overflow fill. Comparator patterns that keep pulsing or stay high after the crossing show whether later pulses are masked. Strobes and comparator highs given outside discharge, and comparator highs given in discharge cycles without a strobe, show whether the capture is correctly gated. Back-to-back conversions with different and random crossings check that the captured state clears at each phase start and that old results stay readable until the end edge.

// File: rtl/xcap_pkg.sv
package xcap_pkg;

  localparam int unsigned XCAP_CODE_W_DEF = 6;
  localparam int unsigned XCAP_COLS_DEF   = 8;

  function automatic int unsigned xcap_sel_w(input int unsigned cols);
    return (cols > 1) ? $clog2(cols) : 1;
  endfunction

  typedef enum logic [1:0] {
    XC_IDLE   = 2'b00,
    XC_START  = 2'b01,
    XC_SAMPLE = 2'b10,
    XC_FINISH = 2'b11
  } xcap_evt_e;

endpackage

// File: rtl/xcap_phase_track.sv
module xcap_phase_track #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             phase_dis,
  input  logic             strobe,
  input  logic [CNT_W-1:0] count,
  output logic             start,
  output logic             sample,
  output logic             commit,
  output logic             done
);
  import xcap_pkg::*;

  localparam logic [CNT_W-1:0] TOP_CODE = {CNT_W{1'b1}};

  logic      dis_q, dis_d, dis_en;
  logic      done_q, done_d, done_en;
  xcap_evt_e evt;

  always_comb begin
    start  = phase_dis & ~dis_q;
    sample = phase_dis & strobe;
    commit = sample & (count == TOP_CODE);
    if (commit)      evt = XC_FINISH;
    else if (start)  evt = XC_START;
    else if (sample) evt = XC_SAMPLE;
    else             evt = XC_IDLE;
  end

  always_comb begin
    dis_en  = (phase_dis != dis_q);
    dis_d   = phase_dis;
    done_d  = (evt == XC_FINISH);
    done_en = (done_d != done_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dis_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (dis_en)  dis_q  <= dis_d;
      if (done_en) done_q <= done_d;
    end
  end

  assign done = done_q;

endmodule

// File: rtl/xcap_column.sv
module xcap_column #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             sample,
  input  logic             commit,
  input  logic             cmp,
  input  logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] res,
  output logic             ovf
);
  localparam logic [CNT_W-1:0] FULL_CODE = {CNT_W{1'b1}};

  logic             got_q, got_d, got_en;
  logic [CNT_W-1:0] pend_q, pend_d;
  logic             pend_en;
  logic [CNT_W-1:0] res_q, res_d;
  logic             ovf_q, ovf_d;
  logic             out_en;
  logic             armed, hit, had_hit;

  always_comb begin
    armed   = start | ~got_q;
    hit     = sample & cmp & armed;
    had_hit = got_q & ~start;

    got_en  = start | hit;
    got_d   = hit | (got_q & ~start);

    pend_en = hit;
    pend_d  = count;

    out_en  = commit;
    if (hit) begin
      res_d = count;
      ovf_d = 1'b0;
    end else if (had_hit) begin
      res_d = pend_q;
      ovf_d = 1'b0;
    end else begin
      res_d = FULL_CODE;
      ovf_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      got_q  <= 1'b0;
      pend_q <= '0;
      res_q  <= '0;
      ovf_q  <= 1'b0;
    end else begin
      if (got_en)  got_q  <= got_d;
      if (pend_en) pend_q <= pend_d;
      if (out_en) begin
        res_q <= res_d;
        ovf_q <= ovf_d;
      end
    end
  end

  assign res = res_q;
  assign ovf = ovf_q;

endmodule

// File: rtl/xcap_readmux.sv
module xcap_readmux #(
  parameter int unsigned NUM_COLS = 8,
  parameter int unsigned CNT_W    = 6,
  parameter int unsigned SEL_W    = 3
) (
  input  logic [NUM_COLS*CNT_W-1:0] res_flat,
  input  logic [NUM_COLS-1:0]       ovf_vec,
  input  logic [SEL_W-1:0]          sel,
  output logic [CNT_W:0]            dout
);
  localparam int unsigned WORD_W = CNT_W + 1;

  logic [WORD_W-1:0] words [NUM_COLS];

  for (genvar g = 0; g < NUM_COLS; g++) begin : g_word
    assign words[g] = {ovf_vec[g], res_flat[g*CNT_W +: CNT_W]};
  end

  always_comb begin
    dout = '0;
    for (int k = 0; k < NUM_COLS; k++) begin
      if (sel == SEL_W'(k)) dout = words[k];
    end
  end

endmodule

// File: rtl/xcap_array.sv
module xcap_array #(
  parameter int unsigned NUM_COLS = xcap_pkg::XCAP_COLS_DEF,
  parameter int unsigned CNT_W    = xcap_pkg::XCAP_CODE_W_DEF,
  parameter int unsigned SEL_W    = xcap_pkg::xcap_sel_w(NUM_COLS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                phase_dis,
  input  logic                strobe,
  input  logic [CNT_W-1:0]    count,
  input  logic [NUM_COLS-1:0] cmp,
  input  logic [SEL_W-1:0]    rd_sel,
  output logic [CNT_W:0]      rd_data,
  output logic                conv_done
);
  logic                      start, sample, commit;
  logic [NUM_COLS*CNT_W-1:0] res_flat;
  logic [NUM_COLS-1:0]       ovf_vec;

  xcap_phase_track #(.CNT_W(CNT_W)) u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase_dis (phase_dis),
    .strobe    (strobe),
    .count     (count),
    .start     (start),
    .sample    (sample),
    .commit    (commit),
    .done      (conv_done)
  );

  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    xcap_column #(.CNT_W(CNT_W)) u_col (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .sample (sample),
      .commit (commit),
      .cmp    (cmp[c]),
      .count  (count),
      .res    (res_flat[c*CNT_W +: CNT_W]),
      .ovf    (ovf_vec[c])
    );
  end

  xcap_readmux #(
    .NUM_COLS (NUM_COLS),
    .CNT_W    (CNT_W),
    .SEL_W    (SEL_W)
  ) u_rd (
    .res_flat (res_flat),
    .ovf_vec  (ovf_vec),
    .sel      (rd_sel),
    .dout     (rd_data)
  );

endmodule

// File: rtl/xcap_array_chk.sv
module xcap_array_chk #(
  parameter int unsigned NUM_COLS = 8,
  parameter int unsigned CNT_W    = 6,
  parameter int unsigned SEL_W    = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                phase_dis,
  input logic                strobe,
  input logic [CNT_W-1:0]    count,
  input logic [NUM_COLS-1:0] cmp,
  input logic [SEL_W-1:0]    rd_sel,
  input logic [CNT_W:0]      rd_data,
  input logic                conv_done
);
  logic end_edge;
  assign end_edge = phase_dis & strobe & (count == {CNT_W{1'b1}});

  AST_DONE_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    end_edge |=> conv_done); // R7

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && !end_edge) |=> !conv_done); // R7

  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_done) |-> $past(end_edge)); // R6

  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(rd_sel) && !conv_done) |-> $stable(rd_data)); // R6

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[CNT_W] |-> (rd_data[CNT_W-1:0] == {CNT_W{1'b1}})); // R5

endmodule

bind xcap_array xcap_array_chk #(
  .NUM_COLS (NUM_COLS),
  .CNT_W    (CNT_W),
  .SEL_W    (SEL_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .phase_dis (phase_dis),
  .strobe    (strobe),
  .count     (count),
  .cmp       (cmp),
  .rd_sel    (rd_sel),
  .rd_data   (rd_data),
  .conv_done (conv_done)
);

// File: tb/sim_xcap_array.sv
`timescale 1ns/1ps
module sim_xcap_array;
  localparam int NC = 8;
  localparam int CW = 6;
  localparam int SW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          phase_dis = 1'b0;
  logic          strobe = 1'b0;
  logic [CW-1:0] count = '0;
  logic [NC-1:0] cmp = '0;
  logic [SW-1:0] rd_sel = '0;
  logic [CW:0]   rd_data;
  logic          conv_done;

  int n_vec = 0;
  int n_bad = 0;
  int cyc = 0;

  // reference model state
  bit m_cap [NC];
  int m_pend [NC];
  int m_res [NC];
  bit m_ovf [NC];
  bit m_done = 0;
  bit m_prev = 0;

  int xs [NC];
  int exp_val [NC];
  bit exp_ovf [NC];

  always #10 clk = ~clk;

  xcap_array u0 (
    .clk(clk), .rst_n(rst_n), .phase_dis(phase_dis), .strobe(strobe),
    .count(count), .cmp(cmp), .rd_sel(rd_sel), .rd_data(rd_data),
    .conv_done(conv_done)
  );

  task automatic check(input string tag, input int got, input int expv);
    n_vec++;
    if (got != expv) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d at cycle %0d", tag, got, expv, cyc);
    end
  endtask

  // behavioural reference, advanced on each rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NC; i++) begin
        m_cap[i] = 0; m_pend[i] = 0; m_res[i] = 0; m_ovf[i] = 0;
      end
      m_done = 0; m_prev = 0;
    end else begin
      bit st, fin;
      st  = phase_dis && !m_prev;
      fin = phase_dis && strobe && (int'(count) == 63);
      for (int i = 0; i < NC; i++) begin
        bit hit, old;
        old = m_cap[i] && !st;
        hit = phase_dis && strobe && cmp[i] && !old;
        if (fin) begin
          if (hit)      begin m_res[i] = int'(count); m_ovf[i] = 0; end
          else if (old) begin m_res[i] = m_pend[i];   m_ovf[i] = 0; end
          else          begin m_res[i] = 63;          m_ovf[i] = 1; end
        end
        if (hit) m_pend[i] = int'(count);
        m_cap[i] = old || hit;
      end
      m_done = fin;
      m_prev = phase_dis;
    end
  end

  // per-clock comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      int s;
      s = int'(rd_sel);
      check("R9 rd_data vs model", int'(rd_data), (int'(m_ovf[s]) << 6) | m_res[s]);
      check("R7 conv_done vs model", int'(conv_done), int'(m_done));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: got %0d expected %0d", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic read_all(input string tag, input bit use_exp);
    for (int i = 0; i < NC; i++) begin
      rd_sel = SW'(i);
      #1;
      if (use_exp) check(tag, int'(rd_data), (int'(exp_ovf[i]) << 6) | exp_val[i]);
      else         check(tag, int'(rd_data), 0);
    end
  endtask

  // one full conversion: idle/charge phases, then discharge with the given crossings
  task automatic convert(input bit noisy);
    phase_dis = 0;
    for (int k = 0; k < 128; k++) begin
      count  = CW'(k);
      strobe = noisy ? 1'($urandom % 2) : 1'b0;
      cmp    = NC'($urandom);
      step();
    end
    phase_dis = 1;
    for (int c = 0; c < 64; c++) begin
      count = CW'(c);
      if (noisy) begin
        strobe = 0;          // R4: comparator high with no strobe
        cmp = '1;
        step();
      end
      strobe = 1;
      for (int i = 0; i < NC; i++)
        cmp[i] = (xs[i] >= 0) && (c >= xs[i]) && ((c == xs[i]) || ($urandom % 2 == 1));
      if (c == 32) begin
        // R6: previous results still readable mid-conversion
        read_all("R6 old result held", 1'b1);
      end
      step();
    end
    phase_dis = 0; strobe = 0; cmp = '0;
    check("R7 done pulse after end", int'(conv_done), 1);
    step();
    check("R7 done one cycle", int'(conv_done), 0);
    for (int i = 0; i < NC; i++) begin
      exp_ovf[i] = (xs[i] < 0);
      exp_val[i] = (xs[i] < 0) ? 63 : xs[i];
    end
    read_all("R2 R3 R5 R10 column result", 1'b1);
  endtask

  initial begin
    rd_sel = '0;
    repeat (3) step();
    check("R1 done in reset", int'(conv_done), 0);
    read_all("R1 reset value", 1'b0);
    rst_n = 1;
    step();
    read_all("R1 after release", 1'b0);
    for (int i = 0; i < NC; i++) begin exp_val[i] = 0; exp_ovf[i] = 0; end

    xs = '{0, 5, 17, 31, 40, 62, 63, -1};       // R10 at column 6, R5 at column 7
    convert(1'b0);
    xs = '{-1, -1, -1, -1, -1, -1, -1, -1};     // R5 all over range, R8 clears
    convert(1'b1);
    xs = '{63, 50, 44, 21, 9, 3, 1, 0};         // R8 reversed order, noisy R4
    convert(1'b1);
    for (int r = 0; r < 4; r++) begin
      for (int i = 0; i < NC; i++) xs[i] = int'($urandom % 65) - 1;
      convert(r[0]);
    end
    repeat (4) step();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule